// File: doc/BRIEF.md
# DDR SDRAM Device-Side Command Decoder

This block sits behind the control pins of a four-bank double data rate SDRAM. On every rising clock edge it samples chip select, the three command strobes, clock enable, the bank select pair and the 13-bit address bus. It classifies each sample as one basic command and pulls out the bank, row, column and precharge options. All results appear on registered outputs one cycle after the sampling edge.

It also models each bank as open or closed and keeps the row that each open bank holds. An access to a closed bank, or an activate to a bank that is already open, raises a one-cycle illegal flag. A flagged command leaves the bank state as it was. Clock enable gates the command stream: a low sample freezes the next edge, and a refresh taken while clock enable falls puts the device in self refresh until clock enable returns high.

The command outputs are plain registered status, sampled by the consumer every cycle. The block has no valid/ready stream and applies no back-pressure, so every command the sampled pins present is either decoded or dropped.

Top module: `ddr_cmd_decoder`

## Requirements
- R1: When chip select (cs_n) is sampled high, the edge decodes to no-operation (cmd_o = 0) and changes no bank state, whatever the other pins carry.
- R2: With cs_n low, {ras_n,cas_n,we_n} selects the command shown on cmd_o one cycle later: 011 activate (1), 101 read (2), 100 write (3), 010 precharge (4), 001 with cke high auto refresh (5), 000 mode register set (7), 111 no-operation (0). The unlisted code 110 also decodes as no-operation.
- R3: An activate to a closed bank opens that bank. It records the full 13-bit address as its row on row_o, with bank_o. The row of bank b is held at open_rows_o[13*b+12 : 13*b] while the bank is open.
- R4: The column (col_o, 11 bits) depends on the DQ_WIDTH parameter. For x4 it is {A11, A9..A0}, which skips A10. For x8 it is A9..A0 zero-extended. For x16 it is A8..A0 zero-extended.
- R5: A read or write with A10 high sets auto_pre_o and leaves the addressed bank closed afterwards. With A10 low, auto_pre_o is 0 and the bank stays open.
- R6: A precharge with A10 high sets pre_all_o and closes every bank. With A10 low, pre_all_o is 0 and only the bank on the bank select pins closes.
- R7: illegal_o rises for one cycle after a read or write to a closed bank, or after an activate to an open bank. Such an activate does not change the stored row.
- R8: When cke is sampled low, the following edge accepts no command: cmd_o shows 0 and the bank state does not change. The first edge after reset is frozen in the same way.
- R9: Code 001 with cke sampled low, on an edge that is not frozen, enters self refresh: cmd_o = 6 and sref_o = 1. sref_o stays high, and commands are ignored, for as long as cke is sampled low. The first high sample of cke clears sref_o, and that edge accepts no command.
- R10: Synchronous active-high rst closes all banks, clears sref_o, illegal_o and the option flags, and sets cmd_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank select |
| addr | input | 13 | Multiplexed row/column address, A10 carries the precharge option |
| cmd_o | output | 3 | Decoded command code (see R2, R9) |
| bank_o | output | 2 | Bank of the decoded command |
| row_o | output | 13 | Row field of the decoded command |
| col_o | output | 11 | Column field for the configured width |
| auto_pre_o | output | 1 | Read/write carried auto precharge |
| pre_all_o | output | 1 | Precharge addressed all banks |
| illegal_o | output | 1 | Last command was illegal for the bank state |
| bank_open_o | output | 4 | Open flag per bank |
| open_rows_o | output | 52 | Stored row per bank, 13 bits each |
| sref_o | output | 1 | Device is in self refresh |

## Verification
The bench goes after the overloaded A10: a design that confused the two uses would either close every bank on an auto-precharged write, or keep a bank open after its A10 read. It repeats an activate to an open bank to catch a tracker that overwrites the row register or misses the flag. It drives a refresh with cke falling, then activates during and at the exit of self refresh, and an activate on the edge after a low cke sample. A design with an off-by-one clock-enable pipeline would open a bank there. It also sends a deselected precharge-all while banks are open, which a decoder that ignored chip select would act on.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_REF  = 3'd5,
    CMD_SREF = 3'd6,
    CMD_MRS  = 3'd7
  } cmd_e;

  localparam int unsigned OPT_BIT = 10;
endpackage

// File: rtl/ddr_cmd_classify.sv
module ddr_cmd_classify
  import ddr_cmd_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke,
  input  logic clk_live,
  input  logic in_sref,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NOP;
    if (clk_live && !in_sref && !cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = cke ? CMD_REF : CMD_SREF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/ddr_col_map.sv
module ddr_col_map #(
  parameter int unsigned ROW_W    = 13,
  parameter int unsigned COL_W    = 11,
  parameter int unsigned DQ_WIDTH = 4
) (
  input  logic [ROW_W-1:0] addr,
  output logic [COL_W-1:0] col
);
  generate
    if (DQ_WIDTH == 4) begin : g_x4
      assign col = COL_W'({addr[11], addr[9:0]});
    end else if (DQ_WIDTH == 8) begin : g_x8
      assign col = COL_W'(addr[9:0]);
    end else begin : g_x16
      assign col = COL_W'(addr[8:0]);
    end
  endgenerate
endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track
  import ddr_cmd_pkg::*;
#(
  parameter int unsigned BA_W  = 2,
  parameter int unsigned ROW_W = 13,
  localparam int unsigned NBANK = 1 << BA_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  cmd_e                   cmd,
  input  logic [BA_W-1:0]        bank,
  input  logic [ROW_W-1:0]       row,
  input  logic                   opt,
  output logic [NBANK-1:0]       open_o,
  output logic [NBANK*ROW_W-1:0] rows_o,
  output logic                   illegal_o
);
  logic hit;
  logic bad;

  assign hit = open_o[bank];
  assign bad = (((cmd == CMD_RD) || (cmd == CMD_WR)) && !hit) ||
               ((cmd == CMD_ACT) && hit);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             is_open;
    logic [ROW_W-1:0] row_r;
    logic             sel;

    assign sel = (bank == BA_W'(b));

    always_ff @(posedge clk) begin
      if (rst) begin
        is_open <= 1'b0;
        row_r   <= '0;
      end else begin
        unique case (cmd)
          CMD_ACT: if (sel && !is_open) begin
            is_open <= 1'b1;
            row_r   <= row;
          end
          CMD_PRE: if (opt || sel) is_open <= 1'b0;
          CMD_RD, CMD_WR: if (sel && is_open && opt) is_open <= 1'b0;
          default: ;
        endcase
      end
    end

    assign open_o[b] = is_open;
    assign rows_o[b*ROW_W +: ROW_W] = row_r;
  end

  always_ff @(posedge clk) begin
    if (rst) illegal_o <= 1'b0;
    else     illegal_o <= bad;
  end

  p_act_open_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_ACT && open_o[bank]) |=> (illegal_o && $stable(rows_o)));

  p_pre_all_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE && opt) |=> (open_o == '0));

  p_auto_pre_r5: assert property (@(posedge clk) disable iff (rst)
    ((cmd == CMD_RD || cmd == CMD_WR) && opt) |=> !open_o[$past(bank)]);

  p_act_opens_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_ACT && !open_o[bank]) |=> (open_o[$past(bank)] && !illegal_o));
endmodule

// File: rtl/ddr_cmd_decoder.sv
module ddr_cmd_decoder
  import ddr_cmd_pkg::*;
#(
  parameter int unsigned BA_W     = 2,
  parameter int unsigned ROW_W    = 13,
  parameter int unsigned DQ_WIDTH = 4,
  localparam int unsigned NBANK   = 1 << BA_W,
  localparam int unsigned COL_W   = ROW_W - 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic                   cke,
  input  logic [BA_W-1:0]        ba,
  input  logic [ROW_W-1:0]       addr,
  output logic [2:0]             cmd_o,
  output logic [BA_W-1:0]        bank_o,
  output logic [ROW_W-1:0]       row_o,
  output logic [COL_W-1:0]       col_o,
  output logic                   auto_pre_o,
  output logic                   pre_all_o,
  output logic                   illegal_o,
  output logic [NBANK-1:0]       bank_open_o,
  output logic [NBANK*ROW_W-1:0] open_rows_o,
  output logic                   sref_o
);
  logic             cke_q;
  logic             sref_q;
  cmd_e             cmd_now;
  cmd_e             cmd_q;
  logic [COL_W-1:0] col_now;
  logic             opt;

  assign opt = addr[OPT_BIT];

  ddr_cmd_classify u_classify (
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .cke      (cke),
    .clk_live (cke_q),
    .in_sref  (sref_q),
    .cmd      (cmd_now)
  );

  ddr_col_map #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_WIDTH(DQ_WIDTH)) u_col (
    .addr (addr),
    .col  (col_now)
  );

  ddr_bank_track #(.BA_W(BA_W), .ROW_W(ROW_W)) u_banks (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd_now),
    .bank      (ba),
    .row       (addr),
    .opt       (opt),
    .open_o    (bank_open_o),
    .rows_o    (open_rows_o),
    .illegal_o (illegal_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q  <= 1'b0;
      sref_q <= 1'b0;
    end else begin
      cke_q <= cke;
      if (sref_q)                 sref_q <= !cke;
      else if (cmd_now == CMD_SREF) sref_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q      <= CMD_NOP;
      bank_o     <= '0;
      row_o      <= '0;
      col_o      <= '0;
      auto_pre_o <= 1'b0;
      pre_all_o  <= 1'b0;
    end else begin
      cmd_q      <= cmd_now;
      bank_o     <= ba;
      row_o      <= addr;
      col_o      <= col_now;
      auto_pre_o <= opt && (cmd_now == CMD_RD || cmd_now == CMD_WR);
      pre_all_o  <= opt && (cmd_now == CMD_PRE);
    end
  end

  assign cmd_o  = cmd_q;
  assign sref_o = sref_q;

  p_desel_nop_r1: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n) |-> (cmd_o == CMD_NOP));

  p_freeze_nop_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(cke, 2) |-> (cmd_o == CMD_NOP));

  p_sref_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (sref_o && !cke) |=> sref_o);

  p_sref_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (sref_o && $past(sref_o)) |-> (cmd_o == CMD_NOP));

  p_reset_state_r10: assert property (@(posedge clk)
    $past(rst) |-> (bank_open_o == '0 && !sref_o && cmd_o == CMD_NOP));
endmodule

// File: tb/sim_ddr_cmd_decoder.sv
module sim_ddr_cmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int DQW = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [2:0]  cmd_o;
  logic [1:0]  bank_o;
  logic [12:0] row_o;
  logic [10:0] col_o;
  logic        auto_pre_o, pre_all_o, illegal_o, sref_o;
  logic [3:0]  bank_open_o;
  logic [51:0] open_rows_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_cmd_decoder #(.DQ_WIDTH(DQW)) u0 (
    .clk, .rst, .cs_n, .ras_n, .cas_n, .we_n, .cke, .ba, .addr,
    .cmd_o, .bank_o, .row_o, .col_o, .auto_pre_o, .pre_all_o,
    .illegal_o, .bank_open_o, .open_rows_o, .sref_o
  );

  // vector: cs_n, rcw[2:0], ba[1:0], addr[12:0], exp_cmd[2:0], exp_ill, exp_open[3:0]
  localparam int NV = 17;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 3'b011, 2'd0, 13'h1ABC, 3'd0, 1'b0, 4'b0000},
    {1'b0, 3'b011, 2'd0, 13'h1ABC, 3'd1, 1'b0, 4'b0001},
    {1'b0, 3'b011, 2'd0, 13'h0005, 3'd1, 1'b1, 4'b0001},
    {1'b0, 3'b101, 2'd1, 13'h0000, 3'd2, 1'b1, 4'b0001},
    {1'b0, 3'b011, 2'd2, 13'h0123, 3'd1, 1'b0, 4'b0101},
    {1'b0, 3'b101, 2'd0, 13'h0011, 3'd2, 1'b0, 4'b0101},
    {1'b0, 3'b100, 2'd2, 13'h0400, 3'd3, 1'b0, 4'b0001},
    {1'b0, 3'b000, 2'd0, 13'h0031, 3'd7, 1'b0, 4'b0001},
    {1'b0, 3'b110, 2'd0, 13'h0000, 3'd0, 1'b0, 4'b0001},
    {1'b0, 3'b011, 2'd3, 13'h0777, 3'd1, 1'b0, 4'b1001},
    {1'b0, 3'b010, 2'd0, 13'h0000, 3'd4, 1'b0, 4'b1000},
    {1'b0, 3'b011, 2'd1, 13'h0042, 3'd1, 1'b0, 4'b1010},
    {1'b1, 3'b010, 2'd0, 13'h0400, 3'd0, 1'b0, 4'b1010},
    {1'b0, 3'b010, 2'd1, 13'h0400, 3'd4, 1'b0, 4'b0000},
    {1'b0, 3'b001, 2'd0, 13'h0000, 3'd5, 1'b0, 4'b0000},
    {1'b0, 3'b100, 2'd3, 13'h0000, 3'd3, 1'b1, 4'b0000},
    {1'b0, 3'b111, 2'd0, 13'h0000, 3'd0, 1'b0, 4'b0000}
  };

  function automatic logic [10:0] exp_col(input logic [12:0] a);
    if (DQW == 4)      return {a[11], a[9:0]};
    else if (DQW == 8) return {1'b0, a[9:0]};
    else               return {2'b00, a[8:0]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge: set pins, pass one rising edge, return at next negedge
  task automatic issue(input logic c, input logic [2:0] rcw, input logic [1:0] b,
                       input logic [12:0] a, input logic k);
    cs_n = c; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a; cke = k;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 cmd", cmd_o, 0); chk("R10 open", bank_open_o, 0);
    chk("R10 sref", sref_o, 0); chk("R10 illegal", illegal_o, 0);
    rst = 1'b0;
    // R8 first edge after reset is frozen
    issue(1'b0, 3'b011, 2'd0, 13'h0001, 1'b1);
    chk("R8 post-reset freeze cmd", cmd_o, 0);
    chk("R8 post-reset freeze open", bank_open_o, 0);

    // table walk: R1 R2 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][26], VEC[i][25:23], VEC[i][22:21], VEC[i][20:8], 1'b1);
      chk($sformatf("R2/R1 cmd v%0d", i), cmd_o, VEC[i][7:5]);
      chk($sformatf("R7 illegal v%0d", i), illegal_o, VEC[i][4]);
      chk($sformatf("R6/R5 open v%0d", i), bank_open_o, VEC[i][3:0]);
    end

    // R3 activate records row
    issue(1'b0, 3'b011, 2'd2, 13'h1F0F, 1'b1);
    chk("R3 row_o", row_o, 13'h1F0F); chk("R3 bank_o", bank_o, 2);
    chk("R3 stored row", open_rows_o[2*13 +: 13], 13'h1F0F);
    // R7 second activate leaves stored row
    issue(1'b0, 3'b011, 2'd2, 13'h0000, 1'b1);
    chk("R7 flag", illegal_o, 1);
    chk("R7 row kept", open_rows_o[2*13 +: 13], 13'h1F0F);
    // R4 column with A10 low, R5 no auto precharge
    issue(1'b0, 3'b101, 2'd2, 13'b0_1_0_1100110011, 1'b1);
    chk("R4 col x4", col_o, exp_col(13'b0_1_0_1100110011));
    chk("R5 no auto_pre", auto_pre_o, 0);
    chk("R5 bank stays open", bank_open_o[2], 1);
    // R4 A10 not part of column, R5 auto precharge
    issue(1'b0, 3'b100, 2'd2, 13'b0_0_1_0000000101, 1'b1);
    chk("R4 col skips A10", col_o, exp_col(13'b0_0_1_0000000101));
    chk("R5 auto_pre", auto_pre_o, 1);
    chk("R5 bank closed", bank_open_o[2], 0);
    // R6 option flag
    issue(1'b0, 3'b011, 2'd1, 13'h0003, 1'b1);
    issue(1'b0, 3'b010, 2'd0, 13'h0000, 1'b1);
    chk("R6 single pre flag", pre_all_o, 0);
    chk("R6 other bank open", bank_open_o, 4'b0010);
    issue(1'b0, 3'b010, 2'd0, 13'h0400, 1'b1);
    chk("R6 all pre flag", pre_all_o, 1);
    chk("R6 all closed", bank_open_o, 0);

    // R8 power-down freeze
    issue(1'b1, 3'b111, 2'd0, 13'h0000, 1'b0);
    issue(1'b0, 3'b011, 2'd1, 13'h0009, 1'b1);
    chk("R8 frozen cmd", cmd_o, 0);
    chk("R8 frozen open", bank_open_o, 0);
    issue(1'b0, 3'b011, 2'd1, 13'h0009, 1'b1);
    chk("R8 resumed cmd", cmd_o, 1);
    issue(1'b0, 3'b010, 2'd0, 13'h0400, 1'b1);

    // R9 self refresh
    issue(1'b0, 3'b001, 2'd0, 13'h0000, 1'b0);
    chk("R9 entry cmd", cmd_o, 6); chk("R9 entry sref", sref_o, 1);
    issue(1'b0, 3'b011, 2'd0, 13'h0000, 1'b0);
    chk("R9 held sref", sref_o, 1); chk("R9 ignored cmd", cmd_o, 0);
    chk("R9 ignored open", bank_open_o, 0);
    issue(1'b0, 3'b011, 2'd0, 13'h0000, 1'b1);
    chk("R9 exit sref", sref_o, 0); chk("R9 exit edge ignored", cmd_o, 0);
    chk("R9 exit open", bank_open_o, 0);
    issue(1'b0, 3'b011, 2'd0, 13'h0000, 1'b1);
    chk("R9 after exit cmd", cmd_o, 1); chk("R9 after exit open", bank_open_o, 4'b0001);

    // R10 mid-run reset
    rst = 1'b1;
    issue(1'b1, 3'b111, 2'd0, 13'h0000, 1'b1);
    chk("R10 mid reset open", bank_open_o, 0);
    chk("R10 mid reset cmd", cmd_o, 0);
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule